// File: doc/BRIEF.md
# Path Signal Label and Remote Defect Monitor

This block watches the two per-frame path overhead bytes of a synchronous optical path: the signal label byte and the path status byte. Each time the frame strobe is high it takes in one label and one status byte and keeps four defect flags up to date:

- label mismatch against a provisioned expected label;
- unequipped path;
- payload defect indication;
- remote defect indication.

It also keeps a persistence-filtered "accepted" label. A single-cycle change pulse is raised whenever any of the four flags toggles.

Three configuration inputs control it. The first picks the label persistence depth. The second picks the remote-defect persistence depth. The third picks how the mismatch and payload-defect flags are derived. In the first mode they come from frame-counted persistence on the raw received label. In the second mode they follow the accepted label at once. Any change to a configuration input restarts every persistence count but keeps the flags as they are. The block is meant to sit after frame alignment and pointer processing, and it drives a status or interrupt layer that lives elsewhere.

Top module: `pathLabelMonitor`

## Requirements
- R1: `acceptedLabel` resets to 0x00. It takes a received label value only when that same value has arrived in N back-to-back frames, and it is updated on the edge that takes in the Nth such frame.
- R2: The label persistence depth N is 3 when `persistSel` is 0 and 5 when `persistSel` is 1. One setting covers the accepted label, the mismatch, unequipped and payload-defect filters.
- R3: With `algoSel` = 0, `plmStatus` becomes 1 after N consecutive frames whose received label mismatches `expLabel`, and becomes 0 after N consecutive matching frames. A label matches when it equals `expLabel`, or when it is 0x01 and `expLabel` is not 0x00.
- R4: In both modes, `uneqStatus` becomes 1 after N consecutive frames carrying label 0x00, and becomes 0 after N consecutive frames carrying any other label.
- R5: With `algoSel` = 0, `pdiStatus` becomes 1 after N consecutive frames whose label lies in 0xE1..0xFC inclusive, and becomes 0 after N consecutive frames outside that range.
- R6: With `algoSel` = 1, `plmStatus` and `pdiStatus` equal the R3 mismatch and R5 range tests applied to `acceptedLabel`, one clock after it, with no further frame counting.
- R7: `rdiStatus` becomes 1 after M consecutive frames with `rxStatus[3]` = 1, and becomes 0 after M consecutive frames with that bit 0. M is 5 when `rdiSel` is 0 and 10 when `rdiSel` is 1.
- R8: A frame that agrees with a flag's current value restarts that flag's count. Only an unbroken run of disagreeing frames changes a flag. Nothing counts without `frameStb`.
- R9: Each of `plmChg`, `uneqChg`, `pdiChg` and `rdiChg` is high for exactly one cycle, in the first cycle its flag shows a new value.
- R10: A change on `persistSel`, `rdiSel` or `algoSel` clears every count, including the accepted-label run, and leaves the flags unchanged. A frame in that same cycle is not counted.
- R11: After reset all four flags and all four change pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStb | input | 1 | One-cycle strobe marking valid overhead bytes |
| rxLabel | input | 8 | Received signal label byte |
| rxStatus | input | 8 | Received path status byte |
| expLabel | input | 8 | Provisioned expected label |
| persistSel | input | 1 | Label persistence depth: 0 for 3 frames, 1 for 5 frames |
| rdiSel | input | 1 | Remote-defect persistence depth: 0 for 5 frames, 1 for 10 frames |
| algoSel | input | 1 | 0 selects raw-label persistence, 1 selects the accepted-label decision |
| acceptedLabel | output | 8 | Persistence-accepted label |
| plmStatus | output | 1 | Label mismatch flag |
| uneqStatus | output | 1 | Unequipped flag |
| pdiStatus | output | 1 | Payload defect indication flag |
| rdiStatus | output | 1 | Remote defect indication flag |
| plmChg | output | 1 | Mismatch flag toggled |
| uneqChg | output | 1 | Unequipped flag toggled |
| pdiChg | output | 1 | Payload defect flag toggled |
| rdiChg | output | 1 | Remote defect flag toggled |

## Verification
The bench targets runs that break one frame short of the threshold. A design that keeps counting across an interruption would raise unequipped or mismatch too early. It also probes the payload-defect range edges at 0xE0, 0xE1, 0xFC and 0xFD, and the 0x01 wildcard label. An off-by-one range compare or a missing wildcard would show up there as a spurious or missing payload-defect or mismatch flag.

A configuration change is made partway through a run. A design that keeps its counts would then clear the mismatch flag two frames early, and one that resets its flags would drop active defects. The accepted-label mode is driven with alternating labels. A design that filters poorly would either move the accepted label or lag the flags behind it. Change pulses are counted against the model's toggle count to catch stretched or missing pulses.

// File: rtl/pathmon_pkg.sv
package pathmon_pkg;

  localparam int LABEL_W = 8;
  localparam logic [LABEL_W-1:0] UNEQ_CODE  = 8'h00;
  localparam logic [LABEL_W-1:0] EQUIP_CODE = 8'h01;
  localparam logic [LABEL_W-1:0] PDI_LO     = 8'hE1;
  localparam logic [LABEL_W-1:0] PDI_HI     = 8'hFC;

  // Strobes from control to datapath
  typedef struct packed {
    logic frame;     // count this frame
    logic clearCnt;  // restart all persistence counts
    logic rawMis;    // received label mismatches expected
    logic rawUneq;   // received label is unequipped
    logic rawPdi;    // received label is a payload-defect code
    logic rdiBit;    // remote defect bit of the status byte
  } monStrobe_t;

  function automatic logic labelMismatch(input logic [LABEL_W-1:0] lbl,
                                         input logic [LABEL_W-1:0] expd);
    logic isMatch;
    isMatch = (lbl == expd) || ((lbl == EQUIP_CODE) && (expd != UNEQ_CODE));
    return !isMatch;
  endfunction

  function automatic logic labelIsPdi(input logic [LABEL_W-1:0] lbl);
    return (lbl >= PDI_LO) && (lbl <= PDI_HI);
  endfunction

endpackage

// File: rtl/pathmon_ctrl.sv
module pathmon_ctrl
  import pathmon_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int RDI_BIT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStb,
  input  logic [LABEL_W-1:0] rxLabel,
  input  logic [STAT_W-1:0]  rxStatus,
  input  logic [LABEL_W-1:0] expLabel,
  input  logic               persistSel,
  input  logic               rdiSel,
  input  logic               algoSel,
  output monStrobe_t         strobes
);

  logic [2:0] cfgNow, cfgPrev;
  logic       cfgChanged;

  assign cfgNow     = {persistSel, rdiSel, algoSel};
  assign cfgChanged = (cfgNow != cfgPrev);

  always_ff @(posedge clk) begin
    if (!rstN) cfgPrev <= '0;
    else       cfgPrev <= cfgNow;
  end

  always_comb begin
    strobes.clearCnt = cfgChanged;
    strobes.frame    = frameStb && !cfgChanged;  // frame during a reconfig is dropped
    strobes.rawMis   = labelMismatch(rxLabel, expLabel);
    strobes.rawUneq  = (rxLabel == UNEQ_CODE);
    strobes.rawPdi   = labelIsPdi(rxLabel);
    strobes.rdiBit   = rxStatus[RDI_BIT];
  end

endmodule

// File: rtl/pathmon_persist.sv
module pathmon_persist #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             stb,
  input  logic             disagree,
  input  logic [CNT_W-1:0] thresh,
  output logic             flip
);

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runInc;

  assign runInc = runCnt + 1'b1;
  assign flip   = !clr && stb && disagree && (runInc >= thresh);

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      runCnt <= '0;
    end else if (stb) begin
      if (!disagree || flip) runCnt <= '0;
      else                   runCnt <= runInc;
    end
  end

endmodule

// File: rtl/pathmon_datapath.sv
module pathmon_datapath
  import pathmon_pkg::*;
#(
  parameter int SHORT_N   = 3,
  parameter int LONG_N    = 5,
  parameter int RDI_SHORT = 5,
  parameter int RDI_LONG  = 10,
  parameter int NUM_DEF   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  monStrobe_t         strobes,
  input  logic [LABEL_W-1:0] rxLabel,
  input  logic [LABEL_W-1:0] expLabel,
  input  logic               persistSel,
  input  logic               rdiSel,
  input  logic               algoSel,
  output logic [LABEL_W-1:0] acceptedLabel,
  output logic [NUM_DEF-1:0] defStatus,
  output logic [NUM_DEF-1:0] defChg
);

  localparam int MAX_N = (RDI_LONG > LONG_N) ? RDI_LONG : LONG_N;
  localparam int CNT_W = $clog2(MAX_N + 1);
  localparam int RDI_IDX = NUM_DEF - 1;

  logic [CNT_W-1:0] labN, rdiN;
  assign labN = persistSel ? CNT_W'(LONG_N)   : CNT_W'(SHORT_N);
  assign rdiN = rdiSel     ? CNT_W'(RDI_LONG) : CNT_W'(RDI_SHORT);

  // Accepted label filter
  logic [LABEL_W-1:0] candLabel, accLabel;
  logic [CNT_W-1:0]   accCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candLabel <= '0;
      accLabel  <= '0;
      accCnt    <= '0;
    end else if (strobes.clearCnt) begin
      accCnt <= '0;
    end else if (strobes.frame) begin
      if (rxLabel == candLabel) begin
        if (accCnt < labN) begin
          accCnt <= accCnt + 1'b1;
          if (accCnt + 1'b1 == labN) accLabel <= rxLabel;
        end
      end else begin
        candLabel <= rxLabel;
        accCnt    <= CNT_W'(1);
      end
    end
  end

  assign acceptedLabel = accLabel;

  // Index 0 mismatch, 1 unequipped, 2 payload defect, 3 remote defect
  logic [NUM_DEF-1:0] rawCond, useFilter, directVal, flip, statusQ, statusD;

  assign rawCond   = {strobes.rdiBit, strobes.rawPdi, strobes.rawUneq, strobes.rawMis};
  assign useFilter = {1'b1, !algoSel, 1'b1, !algoSel};
  assign directVal = {1'b0, labelIsPdi(accLabel), 1'b0, labelMismatch(accLabel, expLabel)};

  for (genvar i = 0; i < NUM_DEF; i++) begin : g_def
    logic [CNT_W-1:0] thr;
    if (i == RDI_IDX) begin : g_rdi
      assign thr = rdiN;
    end else begin : g_lab
      assign thr = labN;
    end

    pathmon_persist #(.CNT_W(CNT_W)) u_persist (
      .clk      (clk),
      .rstN     (rstN),
      .clr      (strobes.clearCnt || !useFilter[i]),
      .stb      (strobes.frame && useFilter[i]),
      .disagree (rawCond[i] ^ statusQ[i]),
      .thresh   (thr),
      .flip     (flip[i])
    );

    assign statusD[i] = useFilter[i] ? (statusQ[i] ^ flip[i]) : directVal[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      defChg  <= '0;
    end else begin
      statusQ <= statusD;
      defChg  <= statusD ^ statusQ;
    end
  end

  assign defStatus = statusQ;

endmodule

// File: rtl/pathLabelMonitor.sv
module pathLabelMonitor
  import pathmon_pkg::*;
#(
  parameter int SHORT_N   = 3,
  parameter int LONG_N    = 5,
  parameter int RDI_SHORT = 5,
  parameter int RDI_LONG  = 10,
  parameter int STAT_W    = 8,
  parameter int RDI_BIT   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic [7:0]        rxLabel,
  input  logic [STAT_W-1:0] rxStatus,
  input  logic [7:0]        expLabel,
  input  logic              persistSel,
  input  logic              rdiSel,
  input  logic              algoSel,
  output logic [7:0]        acceptedLabel,
  output logic              plmStatus,
  output logic              uneqStatus,
  output logic              pdiStatus,
  output logic              rdiStatus,
  output logic              plmChg,
  output logic              uneqChg,
  output logic              pdiChg,
  output logic              rdiChg
);

  localparam int NUM_DEF = 4;

  monStrobe_t         strobes;
  logic [NUM_DEF-1:0] defStatus, defChg;

  pathmon_ctrl #(.STAT_W(STAT_W), .RDI_BIT(RDI_BIT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStb   (frameStb),
    .rxLabel    (rxLabel),
    .rxStatus   (rxStatus),
    .expLabel   (expLabel),
    .persistSel (persistSel),
    .rdiSel     (rdiSel),
    .algoSel    (algoSel),
    .strobes    (strobes)
  );

  pathmon_datapath #(
    .SHORT_N   (SHORT_N),
    .LONG_N    (LONG_N),
    .RDI_SHORT (RDI_SHORT),
    .RDI_LONG  (RDI_LONG),
    .NUM_DEF   (NUM_DEF)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .rxLabel       (rxLabel),
    .expLabel      (expLabel),
    .persistSel    (persistSel),
    .rdiSel        (rdiSel),
    .algoSel       (algoSel),
    .acceptedLabel (acceptedLabel),
    .defStatus     (defStatus),
    .defChg        (defChg)
  );

  assign {rdiStatus, pdiStatus, uneqStatus, plmStatus} = defStatus;
  assign {rdiChg, pdiChg, uneqChg, plmChg}             = defChg;

endmodule

// File: rtl/pathmon_checker.sv
module pathmon_checker
  import pathmon_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       frameStb,
  input logic [7:0] rxLabel,
  input logic [7:0] rxStatus,
  input logic [7:0] expLabel,
  input logic       persistSel,
  input logic       rdiSel,
  input logic       algoSel,
  input logic [7:0] acceptedLabel,
  input logic       plmStatus,
  input logic       uneqStatus,
  input logic       pdiStatus,
  input logic       rdiStatus,
  input logic       plmChg,
  input logic       uneqChg,
  input logic       pdiChg,
  input logic       rdiChg
);

  p_acc_on_frame_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(acceptedLabel) |-> ($past(frameStb) && acceptedLabel == $past(rxLabel)));

  p_uneq_follows_label_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(uneqStatus) |-> ($past(frameStb) && uneqStatus == ($past(rxLabel) == 8'h00)));

  p_rdi_follows_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdiStatus) |-> ($past(frameStb) && rdiStatus == $past(rxStatus[3])));

  p_alg2_plm_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(algoSel))
      |-> plmStatus == labelMismatch($past(acceptedLabel), $past(expLabel)));

  p_alg2_pdi_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(algoSel)) |-> pdiStatus == labelIsPdi($past(acceptedLabel)));

  p_plm_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    plmChg == (plmStatus != $past(plmStatus)));
  p_uneq_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    uneqChg == (uneqStatus != $past(uneqStatus)));
  p_pdi_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    pdiChg == (pdiStatus != $past(pdiStatus)));
  p_rdi_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdiChg == (rdiStatus != $past(rdiStatus)));

  p_cfg_keeps_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !algoSel &&
     {persistSel, rdiSel, algoSel} != $past({persistSel, rdiSel, algoSel}))
      |=> $stable({plmStatus, uneqStatus, pdiStatus, rdiStatus}));

endmodule

bind pathLabelMonitor pathmon_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .frameStb      (frameStb),
  .rxLabel       (rxLabel),
  .rxStatus      (rxStatus),
  .expLabel      (expLabel),
  .persistSel    (persistSel),
  .rdiSel        (rdiSel),
  .algoSel       (algoSel),
  .acceptedLabel (acceptedLabel),
  .plmStatus     (plmStatus),
  .uneqStatus    (uneqStatus),
  .pdiStatus     (pdiStatus),
  .rdiStatus     (rdiStatus),
  .plmChg        (plmChg),
  .uneqChg       (uneqChg),
  .pdiChg        (pdiChg),
  .rdiChg        (rdiChg)
);

// File: tb/tb_pathLabelMonitor.sv
`timescale 1ns/1ps
module tb_pathLabelMonitor;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStb = 1'b0;
  logic [7:0] rxLabel = 8'h00;
  logic [7:0] rxStatus = 8'h00;
  logic [7:0] expLabel = 8'h13;
  logic       persistSel = 1'b0, rdiSel = 1'b0, algoSel = 1'b0;
  logic [7:0] acceptedLabel;
  logic       plmStatus, uneqStatus, pdiStatus, rdiStatus;
  logic       plmChg, uneqChg, pdiChg, rdiChg;

  always #2 clk = ~clk;  // 250 MHz

  pathLabelMonitor dut (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .rxLabel(rxLabel),
    .rxStatus(rxStatus), .expLabel(expLabel), .persistSel(persistSel),
    .rdiSel(rdiSel), .algoSel(algoSel), .acceptedLabel(acceptedLabel),
    .plmStatus(plmStatus), .uneqStatus(uneqStatus), .pdiStatus(pdiStatus),
    .rdiStatus(rdiStatus), .plmChg(plmChg), .uneqChg(uneqChg),
    .pdiChg(pdiChg), .rdiChg(rdiChg)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] acc;
    logic [3:0] st;  // 0 plm, 1 uneq, 2 pdi, 3 rdi
    string      tag;
  } expect_t;
  expect_t sbQ[$];

  // Reference model state
  logic [7:0] mAcc = 8'h00, mCand = 8'h00;
  int         mAccCnt = 0;
  logic [3:0] mSt = 4'b0;
  int         mCnt[4] = '{0, 0, 0, 0};
  int         mToggles[4] = '{0, 0, 0, 0};
  int         seenPulses[4] = '{0, 0, 0, 0};

  function automatic logic mMis(input logic [7:0] l, input logic [7:0] e);
    return !((l == e) || (l == 8'h01 && e != 8'h00));
  endfunction
  function automatic logic mPdi(input logic [7:0] l);
    return (l >= 8'hE1) && (l <= 8'hFC);
  endfunction

  task automatic setSt(input int i, input logic v);
    if (mSt[i] != v) mToggles[i]++;
    mSt[i] = v;
  endtask

  task automatic applyDirect();
    if (algoSel) begin
      setSt(0, mMis(mAcc, expLabel));
      setSt(2, mPdi(mAcc));
    end
  endtask

  task automatic modelFrame(input logic [7:0] l, input logic [7:0] g);
    int n, m;
    logic [3:0] c;
    n = persistSel ? 5 : 3;
    m = rdiSel ? 10 : 5;
    if (l == mCand) begin
      if (mAccCnt < n) begin
        mAccCnt++;
        if (mAccCnt == n) mAcc = l;
      end
    end else begin
      mCand = l;
      mAccCnt = 1;
    end
    c = {g[3], mPdi(l), (l == 8'h00), mMis(l, expLabel)};
    for (int i = 0; i < 4; i++) begin
      if ((i == 0 || i == 2) && algoSel) begin
        mCnt[i] = 0;
      end else if (c[i] != mSt[i]) begin
        mCnt[i]++;
        if (mCnt[i] >= ((i == 3) ? m : n)) begin
          setSt(i, c[i]);
          mCnt[i] = 0;
        end
      end else begin
        mCnt[i] = 0;
      end
    end
    applyDirect();
  endtask

  task automatic pushExp(input string tag);
    expect_t e;
    e.acc = mAcc;
    e.st = mSt;
    e.tag = tag;
    sbQ.push_back(e);
  endtask

  // Driver
  task automatic sendFrame(input logic [7:0] l, input logic [7:0] g, input string tag);
    @(negedge clk);
    frameStb = 1'b1;
    rxLabel = l;
    rxStatus = g;
    @(negedge clk);
    frameStb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    modelFrame(l, g);
    pushExp(tag);
  endtask

  task automatic sendRun(input logic [7:0] l, input logic [7:0] g, input int k, input string tag);
    for (int i = 0; i < k; i++) sendFrame(l, g, tag);
  endtask

  task automatic setCfg(input logic ps, input logic rs, input logic as, input string tag);
    @(negedge clk);
    persistSel = ps;
    rdiSel = rs;
    algoSel = as;
    repeat (3) @(negedge clk);
    mAccCnt = 0;
    for (int i = 0; i < 4; i++) mCnt[i] = 0;
    applyDirect();
    pushExp(tag);
  endtask

  task automatic chk(input string req, input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
    end
  endtask

  // Monitor
  initial begin
    forever begin
      expect_t e;
      wait (sbQ.size() > 0);
      e = sbQ.pop_front();
      chk("R1 accepted label", e.tag, acceptedLabel, e.acc);
      chk(algoSel ? "R6 mismatch" : "R3 mismatch", e.tag, plmStatus, e.st[0]);
      chk("R4 unequipped", e.tag, uneqStatus, e.st[1]);
      chk(algoSel ? "R6 payload defect" : "R5 payload defect", e.tag, pdiStatus, e.st[2]);
      chk("R7 remote defect", e.tag, rdiStatus, e.st[3]);
    end
  end

  // Pulse counters, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (plmChg)  seenPulses[0]++;
      if (uneqChg) seenPulses[1]++;
      if (pdiChg)  seenPulses[2]++;
      if (rdiChg)  seenPulses[3]++;
    end
  end

  // Watchdog
  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset flags", "reset", {plmStatus, uneqStatus, pdiStatus, rdiStatus}, 0);
    chk("R11 reset pulses", "reset", {plmChg, uneqChg, pdiChg, rdiChg}, 0);
    chk("R1 reset accepted", "reset", acceptedLabel, 8'h00);

    // R1: accepted after 3 equal frames
    sendRun(8'h13, 8'h00, 3, "R1 accept at 3");
    // R8 and R4: interrupted run does not set, full run does
    sendRun(8'h00, 8'h00, 2, "R8 short run");
    sendFrame(8'h13, 8'h00, "R8 interrupt");
    sendRun(8'h00, 8'h00, 3, "R4 unequipped set");
    // R3: wildcard label 0x01 matches
    sendRun(8'h01, 8'h00, 3, "R3 wildcard match");
    // R5: range edges
    sendRun(8'hE1, 8'h00, 3, "R5 low edge");
    sendRun(8'hFC, 8'h00, 3, "R5 high edge");
    sendRun(8'hFD, 8'h00, 3, "R5 above range");
    sendRun(8'hE0, 8'h00, 3, "R5 below range");
    // R7: remote defect bit [3], 5 frames
    sendRun(8'h13, 8'h08, 4, "R7 four frames");
    sendFrame(8'h13, 8'h08, "R7 fifth frame");
    // R10 / R2: switch to depth 5
    setCfg(1'b1, 1'b0, 1'b0, "R10 flags held");
    sendRun(8'h55, 8'h08, 4, "R2 four of five");
    sendFrame(8'h55, 8'h08, "R2 fifth frame");
    // R7 depth 10 for remote defect clear
    setCfg(1'b1, 1'b1, 1'b0, "R10 rdi depth change");
    sendRun(8'h55, 8'h00, 9, "R7 nine of ten");
    sendFrame(8'h55, 8'h00, "R7 tenth frame");
    // R10: counts restart on a mid-run reconfiguration
    setCfg(1'b0, 1'b1, 1'b0, "R10 back to depth 3");
    sendRun(8'h13, 8'h00, 2, "R10 partial run");
    setCfg(1'b0, 1'b0, 1'b0, "R10 clear mid run");
    sendRun(8'h13, 8'h00, 2, "R10 restarted run");
    sendFrame(8'h13, 8'h00, "R10 third after clear");
    // R6: accepted-label mode
    setCfg(1'b0, 1'b0, 1'b1, "R6 enter mode");
    sendRun(8'hE5, 8'h00, 2, "R6 not yet accepted");
    sendFrame(8'hE5, 8'h00, "R6 accepted defect code");
    for (int i = 0; i < 3; i++) begin
      sendFrame(8'h13, 8'h00, "R6 alternating");
      sendFrame(8'h14, 8'h00, "R6 alternating");
    end
    sendRun(8'h13, 8'h00, 3, "R6 accept match");
    setCfg(1'b0, 1'b0, 1'b0, "R10 leave mode");
    sendRun(8'hE5, 8'h00, 3, "R5 raw mode again");

    wait (sbQ.size() == 0);
    repeat (4) @(negedge clk);
    chk("R9 mismatch pulses", "end", seenPulses[0], mToggles[0]);
    chk("R9 unequipped pulses", "end", seenPulses[1], mToggles[1]);
    chk("R9 payload pulses", "end", seenPulses[2], mToggles[2]);
    chk("R9 remote pulses", "end", seenPulses[3], mToggles[3]);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule